// File: doc/BRIEF.md
# Memory Security Unlock Controller

This block holds the secured or unsecured state of on-chip memory and decides who may reach secure resources such as flash and RAM. During reset it loads a nonvolatile option byte. From that byte it derives two things: whether the part starts secured, and whether the backdoor key route is allowed. Every access request carries a requester tag. While the part is secured, only code running from secure memory is granted.

There are two ways to release security, and both last only until the next reset.

- **Key route.** Code running from secure memory writes eight key bytes one at a time, then issues a compare strobe. The collected key is checked against a stored 64-bit key. A match unsecures the part. A mismatch locks out the key route.
- **Erase route.** A mass-erase completion event followed by a successful blank check unsecures the part. When the key route has been disabled in the option byte, this is the only way out.

Key traffic from the debug port or from non-secure code is ignored.

Top module: `sec_unlock_ctrl`

## Requirements
- R1: While `rstN` is low at a clock edge, the controller loads `optByte`. `secured` is 0 when bits 1:0 equal 2'b10 and 1 for 00, 01 and 11. The value takes effect from the edge that samples reset.
- R2: `keyEnabled` is 1 exactly when option bits 7:6 equal 2'b10. When it is 0, no key write or compare changes `secured` or `locked`.
- R3: A matching compare unsecures the part. A matching compare means: eight key bytes are written from requester 0 (secure code), then a compare strobe arrives from requester 0. The first byte written is compared with `storedKey[63:56]` and the last with bits 7:0. On a match, `secured` falls one cycle after the strobe.
- R4: Requester codes are 0 secure code, 1 non-secure code, 2 debug port and 3 reserved. Key writes and compares tagged 1, 2 or 3 are ignored and do not count toward the eight bytes.
- R5: A compare strobe is ignored while fewer than eight bytes are held. Bytes written after the eighth are ignored.
- R6: A compare on eight bytes that do not match sets `locked` one cycle after the strobe. From then until reset, every key write and compare is ignored.
- R7: Unlocking by erase works whatever the key-enable value. A pulse on `eraseDone` arms the route. A later `blankDone` with `blankOk`=1 clears `secured` one cycle after it. A `blankDone` with `blankOk`=0 disarms the route without unlocking. A `blankDone` with nothing armed has no effect.
- R8: `accGrant` = `accValid` and (`secured`=0 or `accReqr`=0). `accDeny` = `accValid` and not `accGrant`. Both are combinational from the current request.
- R9: Reset clears any earlier unlock, lockout, collected bytes and armed erase state, and derives the state again from `optByte`.
- R10: When a key write and a compare strobe arrive in the same cycle, the compare is evaluated on the bytes held before that cycle and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; option byte loaded while low |
| optByte | input | 8 | Nonvolatile security option byte |
| storedKey | input | KEY_BYTES*BYTE_W | Stored backdoor key, first byte in the top bits |
| keyWr | input | 1 | Key byte write strobe |
| keyByte | input | BYTE_W | Key byte being written |
| keyCmp | input | 1 | Key compare strobe |
| keyReq | input | 2 | Requester tag for key write and compare |
| eraseDone | input | 1 | Mass erase completed pulse |
| blankDone | input | 1 | Blank check completed pulse |
| blankOk | input | 1 | Blank check result, 1 = blank |
| accValid | input | 1 | Secure-resource access request |
| accReqr | input | 2 | Requester tag for the access |
| accGrant | output | 1 | Access granted |
| accDeny | output | 1 | Access denied |
| secured | output | 1 | Memory currently secured |
| keyEnabled | output | 1 | Backdoor key route allowed |
| locked | output | 1 | Key route locked out after a mismatch |

## Verification
The bench builds the block with its defaults, KEY_BYTES=8 and BYTE_W=8, so the full 64-bit key with its first-byte-on-top ordering is exercised. Those defaults make the eight-byte boundary reachable in a handful of writes, which covers these cases:

- early compares;
- a ninth byte;
- a compare colliding with a write.

A behavioural model with a byte queue runs alongside the design. It is compared every cycle while access requests rotate through all four requester codes. The option bytes used cover both the key-disabled and the start-unsecured encodings.

// File: rtl/sec_unlock_pkg.sv
`timescale 1ns/1ps
package sec_unlock_pkg;
  typedef enum logic [1:0] {
    REQ_SECURE = 2'd0,
    REQ_NONSEC = 2'd1,
    REQ_DEBUG  = 2'd2,
    REQ_RSVD   = 2'd3
  } req_e;

  localparam logic [1:0] FIELD_OPEN = 2'b10;

  typedef struct packed {
    logic shiftEn;
    logic clrCnt;
  } dpCtl_t;
endpackage

// File: rtl/sec_key_dp.sv
`timescale 1ns/1ps
module sec_key_dp
  import sec_unlock_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtl_t                      ctl,
  input  logic [BYTE_W-1:0]           keyByte,
  input  logic [KEY_BYTES*BYTE_W-1:0] storedKey,
  output logic                        cntFull,
  output logic                        keyMatch
);
  localparam int KEY_W = KEY_BYTES * BYTE_W;
  localparam int CNT_W = $clog2(KEY_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(KEY_BYTES);

  logic [KEY_W-1:0] keyBuf;
  logic [CNT_W-1:0] byteCnt;
  logic [KEY_BYTES-1:0] byteEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyBuf  <= '0;
      byteCnt <= '0;
    end else if (ctl.clrCnt) begin
      byteCnt <= '0;
    end else if (ctl.shiftEn) begin
      keyBuf  <= {keyBuf[KEY_W-BYTE_W-1:0], keyByte};
      byteCnt <= byteCnt + 1'b1;
    end
  end

  for (genvar i = 0; i < KEY_BYTES; i++) begin : g_byteCmp
    assign byteEq[i] = keyBuf[i*BYTE_W +: BYTE_W] == storedKey[i*BYTE_W +: BYTE_W];
  end

  assign cntFull  = (byteCnt == CNT_MAX);
  assign keyMatch = &byteEq;

  // R5: the byte count never passes the key length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_MAX);
  // R5: the control never asks for a shift once the buffer is full
  a_r5_no_shift_full: assert property (@(posedge clk) disable iff (!rstN)
    cntFull |-> !ctl.shiftEn);
endmodule

// File: rtl/sec_unlock_ctl.sv
`timescale 1ns/1ps
module sec_unlock_ctl
  import sec_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] optByte,
  input  logic       keyWr,
  input  logic       keyCmp,
  input  logic [1:0] keyReq,
  input  logic       eraseDone,
  input  logic       blankDone,
  input  logic       blankOk,
  input  logic       cntFull,
  input  logic       keyMatch,
  output dpCtl_t     ctl,
  output logic       secured,
  output logic       keyEnabled,
  output logic       locked
);
  logic erasePend;
  logic keyOk;
  logic cmpGo;
  logic blankUnlock;
  req_e reqTag;

  assign reqTag      = req_e'(keyReq);
  assign keyOk       = secured && keyEnabled && !locked && (reqTag == REQ_SECURE);
  assign cmpGo       = keyOk && keyCmp && cntFull;
  assign ctl.shiftEn = keyOk && keyWr && !keyCmp && !cntFull;
  assign ctl.clrCnt  = cmpGo;
  assign blankUnlock = blankDone && erasePend && blankOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secured    <= (optByte[1:0] != FIELD_OPEN);
      keyEnabled <= (optByte[7:6] == FIELD_OPEN);
      locked     <= 1'b0;
      erasePend  <= 1'b0;
    end else begin
      if ((cmpGo && keyMatch) || blankUnlock) secured <= 1'b0;
      if (cmpGo && !keyMatch) locked <= 1'b1;
      if (eraseDone)      erasePend <= 1'b1;
      else if (blankDone) erasePend <= 1'b0;
    end
  end

  // R6: lockout holds until reset
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
  // R2: with the key route disabled no lockout can appear
  a_r2_no_lock_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !keyEnabled |=> !locked);
  // R4: key traffic from untrusted requesters leaves the lockout alone
  a_r4_untrusted_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ((keyWr || keyCmp) && keyReq != 2'd0) |=> $stable(locked));
  // R9: once unsecured, only reset can secure again
  a_r9_unlock_holds: assert property (@(posedge clk) disable iff (!rstN)
    !secured |=> !secured);
endmodule

// File: rtl/sec_unlock_ctrl.sv
`timescale 1ns/1ps
module sec_unlock_ctrl
  import sec_unlock_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  optByte,
  input  logic [KEY_BYTES*BYTE_W-1:0] storedKey,
  input  logic                        keyWr,
  input  logic [BYTE_W-1:0]           keyByte,
  input  logic                        keyCmp,
  input  logic [1:0]                  keyReq,
  input  logic                        eraseDone,
  input  logic                        blankDone,
  input  logic                        blankOk,
  input  logic                        accValid,
  input  logic [1:0]                  accReqr,
  output logic                        accGrant,
  output logic                        accDeny,
  output logic                        secured,
  output logic                        keyEnabled,
  output logic                        locked
);
  dpCtl_t dpCtl;
  logic   cntFull;
  logic   keyMatch;

  sec_unlock_ctl u_ctl (
    .clk(clk), .rstN(rstN), .optByte(optByte),
    .keyWr(keyWr), .keyCmp(keyCmp), .keyReq(keyReq),
    .eraseDone(eraseDone), .blankDone(blankDone), .blankOk(blankOk),
    .cntFull(cntFull), .keyMatch(keyMatch), .ctl(dpCtl),
    .secured(secured), .keyEnabled(keyEnabled), .locked(locked)
  );

  sec_key_dp #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .keyByte(keyByte),
    .storedKey(storedKey), .cntFull(cntFull), .keyMatch(keyMatch)
  );

  assign accGrant = accValid && (!secured || accReqr == 2'd0);
  assign accDeny  = accValid && !accGrant;

  // R8: untrusted requesters never reach secure resources while secured
  a_r8_deny_untrusted: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && secured && accReqr != 2'd0) |-> (accDeny && !accGrant));
  // R8: a valid request always gets exactly one answer
  a_r8_one_answer: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (accGrant != accDeny));
endmodule

// File: tb/test_sec_unlock_ctrl.sv
`timescale 1ns/1ps
module test_sec_unlock_ctrl;
  localparam int KEY_BYTES = 8;
  localparam int BYTE_W    = 8;
  localparam int KEY_W     = KEY_BYTES * BYTE_W;
  localparam logic [KEY_W-1:0] KEY = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rstN = 1'b0;
  logic [7:0]       optByte = 8'hBF;
  logic             keyWr = 1'b0, keyCmp = 1'b0, eraseDone = 1'b0;
  logic             blankDone = 1'b0, blankOk = 1'b0, accValid = 1'b0;
  logic [BYTE_W-1:0] keyByte = '0;
  logic [1:0]       keyReq = 2'd0, accReqr = 2'd0;
  logic accGrant, accDeny, secured, keyEnabled, locked;

  sec_unlock_ctrl #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W)) i_sec_unlock_ctrl (
    .clk(clk), .rstN(rstN), .optByte(optByte), .storedKey(KEY),
    .keyWr(keyWr), .keyByte(keyByte), .keyCmp(keyCmp), .keyReq(keyReq),
    .eraseDone(eraseDone), .blankDone(blankDone), .blankOk(blankOk),
    .accValid(accValid), .accReqr(accReqr), .accGrant(accGrant),
    .accDeny(accDeny), .secured(secured), .keyEnabled(keyEnabled), .locked(locked)
  );

  int    vecs = 0, bad = 0, cyc = 0;
  string phase = "R1";
  bit    started = 0;
  bit    mSec, mKen, mLock, mPend;
  logic [BYTE_W-1:0] mQ[$];

  // behavioural reference
  always @(posedge clk) begin
    logic [KEY_W-1:0] got;
    bit allowed;
    started = 1;
    cyc++;
    if (!rstN) begin
      mSec = optByte[1:0] != 2'b10;
      mKen = optByte[7:6] == 2'b10;
      mLock = 0; mPend = 0; mQ.delete();
    end else begin
      bit unlockNow, lockNow;
      unlockNow = 0; lockNow = 0;
      allowed = mSec && mKen && !mLock && keyReq == 2'd0;
      if (allowed && keyCmp) begin
        if (mQ.size() == KEY_BYTES) begin
          got = '0;
          foreach (mQ[i]) got = {got[KEY_W-BYTE_W-1:0], mQ[i]};
          if (got == KEY) unlockNow = 1; else lockNow = 1;
          mQ.delete();
        end
      end else if (allowed && keyWr && mQ.size() < KEY_BYTES) begin
        mQ.push_back(keyByte);
      end
      if (blankDone && mPend && blankOk) unlockNow = 1;
      if (eraseDone) mPend = 1; else if (blankDone) mPend = 0;
      if (unlockNow) mSec = 0;
      if (lockNow) mLock = 1;
    end
  end

  // rotating access traffic
  always @(posedge clk) begin
    #3;
    accValid = (cyc % 5) != 4;
    accReqr  = 2'(cyc % 4);
  end

  task automatic chk(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (started) begin
    bit expG;
    expG = accValid && (!mSec || accReqr == 2'd0);
    chk(phase, "secured", secured, mSec);
    chk(phase, "keyEnabled", keyEnabled, mKen);
    chk(phase, "locked", locked, mLock);
    chk("R8", "accGrant", accGrant, expG);
    chk("R8", "accDeny", accDeny, accValid && !expG);
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expectState(string tag, bit s, bit l);
    @(negedge clk);
    chk(tag, "secured(direct)", secured, s);
    chk(tag, "locked(direct)", locked, l);
  endtask

  task automatic doReset(logic [7:0] opt);
    optByte = opt; rstN = 0; step(); step(); rstN = 1; step();
  endtask

  task automatic wr(logic [BYTE_W-1:0] b, logic [1:0] r);
    keyWr = 1; keyByte = b; keyReq = r; step(); keyWr = 0;
  endtask

  task automatic cmp(logic [1:0] r);
    keyCmp = 1; keyReq = r; step(); keyCmp = 0;
  endtask

  task automatic keyBytes(int first, int last, logic [1:0] r);
    for (int i = first; i <= last; i++) wr(KEY[KEY_W-1-i*BYTE_W -: BYTE_W], r);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    // R1: secured with key enabled (bits7:6=10, bits1:0=11)
    phase = "R1"; doReset(8'hBF);
    expectState("R1", 1, 0);
    chk("R2", "keyEnabled(direct)", keyEnabled, 1);
    // R4: full key from debug and from non-secure code is ignored
    phase = "R4"; keyBytes(0, 7, 2'd2); cmp(2'd2);
    keyBytes(0, 7, 2'd1); cmp(2'd1); cmp(2'd3);
    expectState("R4", 1, 0);
    // R5: early compare ignored, ninth byte ignored
    phase = "R5"; keyBytes(0, 4, 2'd0); cmp(2'd0);
    expectState("R5", 1, 0);
    wr(8'hEE, 2'd2); keyBytes(5, 7, 2'd0); wr(8'h55, 2'd0);
    // R3: matching compare unsecures
    phase = "R3"; cmp(2'd0);
    expectState("R3", 0, 0);
    // R9: reset re-secures
    phase = "R9"; doReset(8'hBF);
    expectState("R9", 1, 0);
    // R6: mismatch locks, correct key afterwards ignored
    phase = "R6"; keyBytes(0, 6, 2'd0); wr(8'h00, 2'd0); cmp(2'd0);
    expectState("R6", 1, 1);
    keyBytes(0, 7, 2'd0); cmp(2'd0);
    expectState("R6", 1, 1);
    // R9: reset clears lockout; R10: write+compare collision
    phase = "R9"; doReset(8'hBF);
    expectState("R9", 1, 0);
    phase = "R10"; keyBytes(0, 6, 2'd0);
    keyWr = 1; keyByte = KEY[7:0]; keyCmp = 1; keyReq = 2'd0; step();
    keyWr = 0; keyCmp = 0;
    expectState("R10", 1, 0);
    keyBytes(7, 7, 2'd0); cmp(2'd0);
    expectState("R10", 0, 0);
    // R2: key route disabled (bits7:6=00), correct key has no effect
    phase = "R2"; doReset(8'h3F);
    chk("R2", "keyEnabled(direct)", keyEnabled, 0);
    keyBytes(0, 7, 2'd0); cmp(2'd0);
    expectState("R2", 1, 0);
    // R7: blank without erase, failed blank, then erase+blank ok
    phase = "R7"; blankDone = 1; blankOk = 1; step(); blankDone = 0;
    expectState("R7", 1, 0);
    eraseDone = 1; step(); eraseDone = 0;
    blankDone = 1; blankOk = 0; step(); blankDone = 0;
    blankDone = 1; blankOk = 1; step(); blankDone = 0;
    expectState("R7", 1, 0);
    eraseDone = 1; step(); eraseDone = 0; step();
    blankDone = 1; blankOk = 1; step(); blankDone = 0;
    expectState("R7", 0, 0);
    // R1: unsecured field 10 with key field 11
    phase = "R1"; doReset(8'hFE);
    expectState("R1", 0, 0);
    chk("R2", "keyEnabled(direct)", keyEnabled, 0);
    // R1: field 01 is secured
    doReset(8'h7D);
    expectState("R1", 1, 0);
    phase = "R8"; for (int i = 0; i < 12; i++) step();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule